// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit decides where a small 8-bit processor fetches next after a control-transfer instruction, and how many cycles that instruction takes. The decoder passes in the instruction class and its operands together with a one-cycle `issue` strobe: the current program counter, the raw displacement field, a status-bit selector, the status register, a bit already read from a register or I/O location, two operands for an equality compare, the 16-bit pointer register, and a flag that says whether the instruction after this one is two words long. The unit handles relative jumps, jumps through the pointer, conditional branches on any status bit, signed compare branches, and skip-if instructions. Stack handling for calls and returns and interrupt entry are outside this unit.

A small state machine counts out the cycles the instruction occupies. The states are `ST_IDLE` (waiting), `ST_WAIT2` (two cycles left), `ST_WAIT1` (one cycle left) and `ST_DONE` (result shown). An accepted issue moves from `ST_IDLE` or `ST_DONE` to `ST_DONE` for a 1-cycle instruction, to `ST_WAIT1` for 2 cycles, and to `ST_WAIT2` for 3 cycles. `ST_WAIT2` always moves to `ST_WAIT1`, and `ST_WAIT1` always moves to `ST_DONE`. `ST_DONE` goes back to `ST_IDLE` unless a new issue is accepted. `busy` is high in the wait states. The new program counter and the cycle count appear on the final cycle, with `pc_valid` high.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset, `busy`, `pc_valid`, `pc_next` and `cycles` are all zero.
- R2: Op code 0 (relative jump) gives `pc_cur + sext(disp[11:0]) + 1`, taken modulo 2^PC_W, with `cycles` = 2.
- R3: Op code 1 (pointer jump) gives `pc_next` = `ptr` in the low 16 bits and zero in every upper bit, with `cycles` = 2.
- R4: Op code 2 branches when `status[flag_sel]` is 1, and op code 3 branches when it is 0. A taken branch gives `pc_cur + sext(disp[6:0]) + 1` in 2 cycles. A branch that is not taken gives `pc_cur + 1` in 1 cycle. Status bit positions are carry 0, zero 1, negative 2, overflow 3. An unsigned same-or-higher branch is therefore op 3 with `flag_sel` = 0, and an unsigned lower branch is op 2 with `flag_sel` = 0.
- R5: Op code 4 (signed greater-or-equal) is taken when `status[2] ^ status[3]` is 0. Op code 5 (signed less-than) is taken when that value is 1. The target and timing follow R4.
- R6: Op code 6 skips when `cmp_a == cmp_b`.
- R7: Op code 7 skips when `test_bit` is 0, and op code 8 skips when `test_bit` is 1.
- R8: When a skip condition fails, the result is `pc_cur + 1` with `cycles` = 1. When it holds, the result is `pc_cur + 2` with `cycles` = 2 if `next_two_word` is 0, and `pc_cur + 3` with `cycles` = 3 if `next_two_word` is 1.
- R9: For an instruction of N cycles accepted at a clock edge, `busy` is high for the N-1 cycles that follow. `pc_valid` is high for exactly one cycle, N edges after the issue edge. `pc_next` and `cycles` keep their previous values until that cycle.
- R10: An `issue` while `busy` is high is ignored: the result and the timing of the instruction in progress are unchanged.
- R11: An `issue` with an op code from 9 to 15 is ignored: `pc_valid` stays low and `pc_next` is unchanged.
- R12: Target arithmetic wraps modulo 2^PC_W in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Instruction present this cycle |
| op | input | 4 | Instruction class code (0..8) |
| pc_cur | input | PC_W | Program counter of the instruction |
| disp | input | 12 | Raw displacement field |
| flag_sel | input | 3 | Status bit tested by ops 2 and 3 |
| status | input | 8 | Status register |
| test_bit | input | 1 | Bit read for ops 7 and 8 |
| cmp_a | input | 8 | First compare operand for op 6 |
| cmp_b | input | 8 | Second compare operand for op 6 |
| ptr | input | 16 | Pointer register for op 1 |
| next_two_word | input | 1 | The following instruction is two words long |
| busy | output | 1 | Instruction still occupying cycles |
| pc_valid | output | 1 | `pc_next` and `cycles` valid this cycle |
| pc_next | output | PC_W | Resolved program counter |
| cycles | output | 2 | Cycle count of the resolved instruction |

## Verification
Each branch op is driven with the status register swept so that both the taken and the not-taken outcome occur. This separates a mix-up of set and clear polarity, and separates the signed N-xor-V test from a test of a single flag. Skips are tried with the condition true and false and with both lengths of the following instruction, which separates the three cycle counts and the three PC increments. Positive and negative displacements at their field limits, starting from PC values at the two ends of the range, expose a sign-extension or wrap error. Issues during busy, back-to-back issues in the done cycle, undefined op codes, and a long random mix compare every output against the model on every clock.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    typedef enum logic [3:0] {
        OP_JMP_REL   = 4'd0,
        OP_JMP_PTR   = 4'd1,
        OP_BR_SET    = 4'd2,
        OP_BR_CLR    = 4'd3,
        OP_BR_SGE    = 4'd4,
        OP_BR_SLT    = 4'd5,
        OP_SKIP_EQ   = 4'd6,
        OP_SKIP_BCLR = 4'd7,
        OP_SKIP_BSET = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT2 = 2'd1,
        ST_WAIT1 = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

    localparam int NEG_BIT = 2;
    localparam int OVF_BIT = 3;
endpackage

// File: rtl/bsd_resolve.sv
module bsd_resolve
    import bsd_pkg::*;
#(
    parameter int PC_W       = 22,
    parameter int PTR_W      = 16,
    parameter int BR_DISP_W  = 7,
    parameter int JMP_DISP_W = 12,
    parameter int FLAG_W     = 8,
    parameter int DATA_W     = 8,
    localparam int SEL_W     = $clog2(FLAG_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            op_i,
    input  logic [PC_W-1:0]       pc_i,
    input  logic [JMP_DISP_W-1:0] disp_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [FLAG_W-1:0]     status_i,
    input  logic                  bit_i,
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    input  logic [PTR_W-1:0]      ptr_i,
    input  logic                  two_word_i,
    output logic                  ok_o,
    output logic [PC_W-1:0]       tgt_o,
    output logic [1:0]            n_o
);
    logic [PC_W-1:0] br_off, jmp_off, pc_inc;
    logic            sgn_lt, br_take, skip_hit;

    assign br_off  = {{(PC_W-BR_DISP_W){disp_i[BR_DISP_W-1]}}, disp_i[BR_DISP_W-1:0]};
    assign jmp_off = {{(PC_W-JMP_DISP_W){disp_i[JMP_DISP_W-1]}}, disp_i};
    assign pc_inc  = pc_i + PC_W'(1);
    assign sgn_lt  = status_i[NEG_BIT] ^ status_i[OVF_BIT];

    always_comb begin
        ok_o     = 1'b1;
        tgt_o    = pc_inc;
        n_o      = 2'd1;
        br_take  = 1'b0;
        skip_hit = 1'b0;
        case (op_e'(op_i))
            OP_JMP_REL: begin
                tgt_o = pc_inc + jmp_off;
                n_o   = 2'd2;
            end
            OP_JMP_PTR: begin
                tgt_o = PC_W'(ptr_i);
                n_o   = 2'd2;
            end
            OP_BR_SET:    br_take  = status_i[sel_i];
            OP_BR_CLR:    br_take  = !status_i[sel_i];
            OP_BR_SGE:    br_take  = !sgn_lt;
            OP_BR_SLT:    br_take  = sgn_lt;
            OP_SKIP_EQ:   skip_hit = (a_i == b_i);
            OP_SKIP_BCLR: skip_hit = !bit_i;
            OP_SKIP_BSET: skip_hit = bit_i;
            default:      ok_o     = 1'b0;
        endcase
        if (br_take) begin
            tgt_o = pc_inc + br_off;
            n_o   = 2'd2;
        end
        if (skip_hit) begin
            tgt_o = two_word_i ? pc_i + PC_W'(3) : pc_i + PC_W'(2);
            n_o   = two_word_i ? 2'd3 : 2'd2;
        end
    end

    // R8: cycle count stays within one to three.
    assert_cycle_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (n_o != 2'd0));

    // R4: a single-cycle outcome always falls through to the next word.
    assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && n_o == 2'd1) |-> (tgt_o == pc_i + PC_W'(1)));

    generate
        if (PC_W > PTR_W) begin : g_upper
            // R3: a pointer jump leaves every upper PC bit at zero.
            assert_ptr_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == 4'd1) |-> (tgt_o[PC_W-1:PTR_W] == '0));
        end
    endgenerate
endmodule

// File: rtl/bsd_seq.sv
module bsd_seq
    import bsd_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic            ok_i,
    input  logic [PC_W-1:0] tgt_i,
    input  logic [1:0]      n_i,
    output logic            busy_o,
    output logic            valid_o,
    output logic [PC_W-1:0] pc_o,
    output logic [1:0]      cyc_o
);
    st_e             st_q, st_d;
    logic [PC_W-1:0] pend_q;
    logic [1:0]      pend_n_q;
    logic            accept;

    assign accept = issue_i && ok_i && (st_q == ST_IDLE || st_q == ST_DONE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (accept)
                    st_d = (n_i == 2'd1) ? ST_DONE : (n_i == 2'd2) ? ST_WAIT1 : ST_WAIT2;
                else
                    st_d = ST_IDLE;
            end
            ST_WAIT2: st_d = ST_WAIT1;
            ST_WAIT1: st_d = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            pend_q   <= '0;
            pend_n_q <= '0;
            pc_o     <= '0;
            cyc_o    <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                pend_q   <= tgt_i;
                pend_n_q <= n_i;
                if (n_i == 2'd1) begin
                    pc_o  <= tgt_i;
                    cyc_o <= n_i;
                end
            end else if (st_q == ST_WAIT1) begin
                pc_o  <= pend_q;
                cyc_o <= pend_n_q;
            end
        end
    end

    always_comb begin
        busy_o  = (st_q == ST_WAIT2) || (st_q == ST_WAIT1);
        valid_o = (st_q == ST_DONE);
    end

    // R9: a one-cycle instruction shows its result at the next edge.
    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && n_i == 2'd1) |=> (valid_o && !busy_o));

    // R9: a two-cycle instruction is busy for one cycle, then done.
    assert_two_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && n_i == 2'd2) |=> (busy_o && !valid_o) ##1 valid_o);

    // R10: an issue while busy does not disturb the pending result.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && issue_i) |=> $stable(pend_q));

    // R11: an undefined class never produces a result.
    assert_undef_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !ok_i && !busy_o) |=> (!valid_o && $stable(pc_o)));
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit #(
    parameter int PC_W       = 22,
    parameter int PTR_W      = 16,
    parameter int BR_DISP_W  = 7,
    parameter int JMP_DISP_W = 12,
    parameter int FLAG_W     = 8,
    parameter int DATA_W     = 8,
    localparam int SEL_W     = $clog2(FLAG_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [3:0]            op,
    input  logic [PC_W-1:0]       pc_cur,
    input  logic [JMP_DISP_W-1:0] disp,
    input  logic [SEL_W-1:0]      flag_sel,
    input  logic [FLAG_W-1:0]     status,
    input  logic                  test_bit,
    input  logic [DATA_W-1:0]     cmp_a,
    input  logic [DATA_W-1:0]     cmp_b,
    input  logic [PTR_W-1:0]      ptr,
    input  logic                  next_two_word,
    output logic                  busy,
    output logic                  pc_valid,
    output logic [PC_W-1:0]       pc_next,
    output logic [1:0]            cycles
);
    logic            ok;
    logic [PC_W-1:0] tgt;
    logic [1:0]      n;

    bsd_resolve #(
        .PC_W(PC_W), .PTR_W(PTR_W), .BR_DISP_W(BR_DISP_W),
        .JMP_DISP_W(JMP_DISP_W), .FLAG_W(FLAG_W), .DATA_W(DATA_W)
    ) u_resolve (
        .clk(clk), .rst_n(rst_n), .op_i(op), .pc_i(pc_cur), .disp_i(disp),
        .sel_i(flag_sel), .status_i(status), .bit_i(test_bit), .a_i(cmp_a),
        .b_i(cmp_b), .ptr_i(ptr), .two_word_i(next_two_word),
        .ok_o(ok), .tgt_o(tgt), .n_o(n)
    );

    bsd_seq #(.PC_W(PC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .ok_i(ok), .tgt_i(tgt),
        .n_i(n), .busy_o(busy), .valid_o(pc_valid), .pc_o(pc_next), .cyc_o(cycles)
    );

    // R9: the done cycle never overlaps a wait cycle.
    assert_valid_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> !busy);
endmodule

// File: tb/sim_branch_skip_unit.sv
module sim_branch_skip_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 22;
    localparam logic [PC_W-1:0] PC_MAX = '1;

    logic clk = 1'b0, rst_n = 1'b0, issue = 1'b0, test_bit = 1'b0, next_two_word = 1'b0;
    logic [3:0] op = '0;
    logic [PC_W-1:0] pc_cur = '0;
    logic [11:0] disp = '0;
    logic [2:0] flag_sel = '0;
    logic [7:0] status = '0, cmp_a = '0, cmp_b = '0;
    logic [15:0] ptr = '0;
    logic busy, pc_valid;
    logic [PC_W-1:0] pc_next;
    logic [1:0] cycles;

    branch_skip_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    string tag = "R1";
    bit m_busy = 0, m_valid = 0;
    logic [PC_W-1:0] m_pc = '0, m_pend = '0;
    int m_cyc = 0, m_pendn = 0, m_rem = 0;

    function automatic void reference(output logic [PC_W-1:0] tg, output int n);
        int k7, k12;
        bit take, hit;
        k7   = disp[6] ? int'(disp[6:0]) - 128 : int'(disp[6:0]);
        k12  = disp[11] ? int'(disp) - 4096 : int'(disp);
        take = 0;
        hit  = 0;
        tg   = pc_cur + 1;
        n    = 1;
        case (op)
            4'd0: begin tg = pc_cur + PC_W'(k12) + 1; n = 2; end
            4'd1: begin tg = {{(PC_W-16){1'b0}}, ptr}; n = 2; end
            4'd2: take = status[flag_sel];
            4'd3: take = !status[flag_sel];
            4'd4: take = (status[2] == status[3]);
            4'd5: take = (status[2] != status[3]);
            4'd6: hit = (cmp_a == cmp_b);
            4'd7: hit = !test_bit;
            4'd8: hit = test_bit;
            default: ;
        endcase
        if (take) begin tg = pc_cur + PC_W'(k7) + 1; n = 2; end
        if (hit) begin n = next_two_word ? 3 : 2; tg = pc_cur + PC_W'(n); end
    endfunction

    function automatic void predict();
        logic [PC_W-1:0] tg;
        int n;
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_pc = '0; m_cyc = 0; m_rem = 0;
        end else if (m_rem > 0) begin
            m_rem--;
            if (m_rem == 0) begin
                m_busy = 0; m_valid = 1; m_pc = m_pend; m_cyc = m_pendn;
            end
        end else begin
            m_valid = 0;
            if (issue && op <= 4'd8) begin
                reference(tg, n);
                if (n == 1) begin
                    m_valid = 1; m_pc = tg; m_cyc = 1;
                end else begin
                    m_busy = 1; m_pend = tg; m_pendn = n; m_rem = n - 1;
                end
            end
        end
    endfunction

    task automatic compare();
        checks++;
        if (busy !== m_busy || pc_valid !== m_valid || pc_next !== m_pc || cycles !== 2'(m_cyc)) begin
            fails++;
            $display("FAIL %s: busy=%0b valid=%0b pc=%0h cyc=%0d expected busy=%0b valid=%0b pc=%0h cyc=%0d",
                     tag, busy, pc_valid, pc_next, cycles, m_busy, m_valid, m_pc, m_cyc);
        end
    endtask

    task automatic cyc();
        predict();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input string t, input logic [3:0] o, input logic [PC_W-1:0] pc,
                       input logic [11:0] d, input bit gap);
        tag = t; op = o; pc_cur = pc; disp = d; issue = 1'b1;
        cyc();
        issue = 1'b0;
        while (m_busy) cyc();
        if (gap) cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R2 relative jumps, extreme displacements
        run("R2", 4'd0, 22'h000100, 12'h7FF, 1);
        run("R2", 4'd0, 22'h000100, 12'h800, 1);
        // R3 pointer jump clears upper bits
        ptr = 16'hBEEF;
        run("R3", 4'd1, 22'h3F0000, 12'h000, 1);
        // R4 every status bit, both polarities, both flag values
        for (int s = 0; s < 8; s++) begin
            flag_sel = 3'(s);
            status = 8'h01 << s;
            run("R4", 4'd2, 22'h001000, 12'h03F, 1);
            run("R4", 4'd3, 22'h001000, 12'h040, 1);
            status = ~(8'h01 << s);
            run("R4", 4'd2, 22'h001000, 12'h03F, 1);
            run("R4", 4'd3, 22'h001000, 12'h040, 1);
        end
        // R5 signed compare: all N/V combinations
        for (int nv = 0; nv < 4; nv++) begin
            status = 8'(nv << 2);
            run("R5", 4'd4, 22'h002000, 12'h07E, 1);
            run("R5", 4'd5, 22'h002000, 12'h005, 1);
        end
        // R6 / R7 / R8 skips with both lengths
        for (int w = 0; w < 2; w++) begin
            next_two_word = w[0];
            cmp_a = 8'h5A; cmp_b = 8'h5A; run("R6", 4'd6, 22'h000040, 12'h0, 1);
            cmp_b = 8'h5B;                run("R6", 4'd6, 22'h000040, 12'h0, 1);
            test_bit = 0; run("R7", 4'd7, 22'h000050, 12'h0, 1);
            run("R7", 4'd8, 22'h000050, 12'h0, 1);
            test_bit = 1; run("R8", 4'd7, 22'h000050, 12'h0, 1);
            run("R8", 4'd8, 22'h000050, 12'h0, 1);
        end
        // R12 wrap at both ends
        run("R12", 4'd0, PC_MAX, 12'h000, 1);
        status = 8'h01; flag_sel = 3'd0;
        run("R12", 4'd2, '0, 12'h07C, 1);
        next_two_word = 1; test_bit = 1;
        run("R12", 4'd8, PC_MAX - 1, 12'h0, 1);
        // R10 issue while busy is ignored
        next_two_word = 1; test_bit = 0; ptr = 16'h1234;
        tag = "R10"; op = 4'd7; pc_cur = 22'h000300; issue = 1'b1;
        cyc();
        op = 4'd1; cyc(); cyc();
        issue = 1'b0;
        while (m_busy) cyc();
        cyc();
        // R11 undefined op codes
        for (int u = 9; u < 16; u++) run("R11", 4'(u), 22'h000777, 12'h001, 1);
        // R9 back-to-back and random mix
        for (int i = 0; i < 400; i++) begin
            status = 8'($urandom); flag_sel = 3'($urandom); test_bit = 1'($urandom);
            cmp_a = 8'($urandom % 4); cmp_b = 8'($urandom % 4); ptr = 16'($urandom);
            next_two_word = 1'($urandom);
            run("R9", 4'($urandom % 10), PC_W'($urandom), 12'($urandom), 1'($urandom));
        end
        repeat (2) cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule